// File: doc/BRIEF.md
# Pipeline Timeslice Trigger Manager

This block keeps the digital state of an analog sample pipeline that has 48 storage slots. Each pipeline advance stores the current sample in the slot under the write pointer and moves the pointer on. A trigger looks back a programmed number of advances. It marks the slot written at that point as protected, and it queues that slot's address for later readout. The analog storage is not part of this block. Only the addresses, the protection marks and the readout queue are kept here.

The queue holds four entries. Its depth is also the limit on how many slots can be protected at one time. When the write pointer comes round to a protected slot, it steps over it. After the slot has been read out, a release input frees the oldest protected slot and removes it from the queue. A trigger that finds the queue full is lost, and a sticky flag records the loss. A pipeline reset input clears the whole state in one cycle.

Top module: `slice_trig_mgr`

## Requirements
- R1: After `rst`, or one cycle after `pipe_rst`, `wr_addr` is 0, `head_count` is 0, `head_addr` is 0, `trig_dropped` is 0 and no slot is protected. `pipe_rst` overrides every other input.
- R2: Each cycle with `pipe_adv` high moves `wr_addr` to the next slot, with wrap from 47 to 0. With `pipe_adv` low, `wr_addr` holds.
- R3: An advance steps over every protected slot and stops on the first unprotected slot that follows.
- R4: A trigger targets the slot that was written `latency` advances earlier, counting the slots actually written, so skipped slots are not counted. Legal values of `latency` are 1 to 47.
- R5: An accepted trigger protects the targeted slot and adds its address at the tail of the queue. `head_count` gives the queue occupancy (0 to 4), and its value changes by at most one per cycle.
- R6: A trigger that arrives while `head_count` is 4 is discarded, even when a release arrives in the same cycle. It sets `trig_dropped`, and `trig_dropped` stays high until a reset.
- R7: A release removes the oldest queued slot and unprotects it, so `head_addr` shows the next-oldest slot. A release while the queue is empty has no effect.
- R8: A trigger is ignored, without touching `trig_dropped`, in three cases: `latency` is 0 or above 47; fewer than `latency` advances have happened since the last reset; or the targeted slot is already protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_rst | input | 1 | Synchronous pipeline clear (marks, queue, pointers, flag) |
| pipe_adv | input | 1 | Pipeline advance: store into current slot and move on |
| latency | input | 6 | Trigger look-back, in advances (1 to 47) |
| trig_in | input | 1 | Trigger: protect and queue the slot written `latency` advances ago |
| rel_in | input | 1 | Release the oldest queued slot |
| wr_addr | output | 6 | Slot the next advance writes |
| head_addr | output | 6 | Oldest queued slot, 0 when the queue is empty |
| head_count | output | 3 | Queue occupancy |
| trig_dropped | output | 1 | Sticky flag: a trigger was lost to a full queue |

## Verification
The bench uses the default values of 48 slots and a queue depth of four. With these values it can drive the write pointer through a full wrap in about forty advances. Four triggers fill the queue, so the full-queue drop and the skip over three adjacent protected slots both come up in a short run. One trigger is placed after a skip, and it hits a slot different from the one a plain address subtraction would give. This shows that the look-back counts written slots and not address distance.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {
    TRG_IDLE,
    TRG_PUSH,
    TRG_DROP,
    TRG_SKIP
  } trg_act_e;
endpackage

// File: rtl/slice_history.sv
// Ring of recently written slot addresses; the tap returns the slot written
// lat advances ago, counting only real writes.
module slice_history #(
  parameter int N_SLOTS = 48,
  parameter int AW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [AW-1:0] wr_slot,
  input  logic [AW-1:0] lat,
  output logic [AW-1:0] tap_slot,
  output logic          tap_ok
);
  localparam logic [AW:0]   N_EXT = (AW+1)'(N_SLOTS);
  localparam logic [AW-1:0] LAST  = AW'(N_SLOTS - 1);

  logic [AW-1:0] ring [N_SLOTS];
  logic [AW-1:0] put_ptr;
  logic [AW-1:0] fill;
  logic [AW:0]   idx_raw;
  logic [AW-1:0] idx;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (adv) ring[put_ptr] <= wr_slot;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      put_ptr <= '0;
      fill    <= '0;
    end else if (adv) begin
      put_ptr <= (put_ptr == LAST) ? '0 : put_ptr + 1'b1;
      if (fill != LAST) fill <= fill + 1'b1;
    end
  end

  always_comb begin
    idx_raw = {1'b0, put_ptr} + N_EXT - {1'b0, lat};
    if (idx_raw >= N_EXT) idx = AW'(idx_raw - N_EXT);
    else                  idx = idx_raw[AW-1:0];
    tap_slot = ring[idx];
    tap_ok   = (lat != '0) && ({1'b0, lat} < N_EXT) && (fill >= lat);
  end
endmodule

// File: rtl/slice_fifo.sv
// Small address queue; caller never pushes when full nor pops when empty.
module slice_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] din,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  logic [AW-1:0] store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PLAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PLAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = (count != '0) ? store[rd_ptr] : '0;
endmodule

// File: rtl/slice_mask.sv
// Protection bitmap and write pointer with skip-ahead over protected slots.
module slice_mask #(
  parameter int N_SLOTS = 48,
  parameter int AW      = 6,
  parameter int LOOK    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          set_en,
  input  logic [AW-1:0] set_slot,
  input  logic          rel_en,
  input  logic [AW-1:0] rel_slot,
  input  logic [AW-1:0] query_slot,
  output logic          query_prot,
  output logic [AW-1:0] wp
);
  localparam logic [AW-1:0] LAST = AW'(N_SLOTS - 1);

  logic [N_SLOTS-1:0] prot, eff;
  logic [AW-1:0]      nxt;
  logic [AW-1:0]      cand [LOOK+1];
  logic [LOOK-1:0]    free_at;

  always_comb begin
    eff = prot;
    if (rel_en) eff[rel_slot] = 1'b0;
    if (set_en) eff[set_slot] = 1'b1;
  end

  assign cand[0] = wp;
  for (genvar k = 0; k < LOOK; k++) begin : g_look
    assign cand[k+1]  = (cand[k] == LAST) ? '0 : cand[k] + 1'b1;
    assign free_at[k] = ~eff[cand[k+1]];
  end

  always_comb begin
    nxt = cand[1];
    for (int k = LOOK - 1; k >= 0; k--) begin
      if (free_at[k]) nxt = cand[k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prot <= '0;
      wp   <= '0;
    end else begin
      prot <= eff;
      if (adv) wp <= nxt;
    end
  end

  assign query_prot = prot[query_slot];
endmodule

// File: rtl/slice_trig_mgr.sv
module slice_trig_mgr #(
  parameter  int N_SLOTS    = 48,
  parameter  int FIFO_DEPTH = 4,
  localparam int AW         = $clog2(N_SLOTS),
  localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_rst,
  input  logic          pipe_adv,
  input  logic [AW-1:0] latency,
  input  logic          trig_in,
  input  logic          rel_in,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] head_addr,
  output logic [CW-1:0] head_count,
  output logic          trig_dropped
);
  import slice_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);

  logic [AW-1:0] tap_slot;
  logic          tap_ok, tap_prot;
  logic          do_push, do_pop;
  trg_act_e      act;

  slice_history #(.N_SLOTS(N_SLOTS), .AW(AW)) u_hist (
    .clk(clk), .rst(rst), .clr(pipe_rst), .adv(pipe_adv),
    .wr_slot(wr_addr), .lat(latency), .tap_slot(tap_slot), .tap_ok(tap_ok)
  );

  always_comb begin
    act = TRG_IDLE;
    if (trig_in) begin
      if (!tap_ok || tap_prot)  act = TRG_SKIP;
      else if (head_count == FULL) act = TRG_DROP;
      else                      act = TRG_PUSH;
    end
  end

  assign do_push = (act == TRG_PUSH);
  assign do_pop  = rel_in && (head_count != '0);

  slice_fifo #(.DEPTH(FIFO_DEPTH), .AW(AW), .CW(CW)) u_fifo (
    .clk(clk), .rst(rst), .clr(pipe_rst), .push(do_push), .din(tap_slot),
    .pop(do_pop), .head(head_addr), .count(head_count)
  );

  slice_mask #(.N_SLOTS(N_SLOTS), .AW(AW), .LOOK(FIFO_DEPTH + 1)) u_mask (
    .clk(clk), .rst(rst), .clr(pipe_rst), .adv(pipe_adv),
    .set_en(do_push), .set_slot(tap_slot),
    .rel_en(do_pop), .rel_slot(head_addr),
    .query_slot(tap_slot), .query_prot(tap_prot), .wp(wr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || pipe_rst)      trig_dropped <= 1'b0;
    else if (act == TRG_DROP) trig_dropped <= 1'b1;
  end
endmodule

// File: rtl/slice_trig_mgr_chk.sv
module slice_trig_mgr_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int AW         = 6,
  parameter int CW         = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          pipe_rst,
  input logic          pipe_adv,
  input logic          trig_in,
  input logic          rel_in,
  input logic [AW-1:0] wr_addr,
  input logic [CW-1:0] head_count,
  input logic          trig_dropped
);
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    pipe_rst |=> (wr_addr == '0 && head_count == '0 && !trig_dropped));

  assert_hold_ptr_R2: assert property (@(posedge clk) disable iff (rst)
    (!pipe_adv && !pipe_rst) |=> $stable(wr_addr));

  assert_adv_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (pipe_adv && !pipe_rst) |=> (wr_addr != $past(wr_addr)));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    head_count <= FULL);

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    !pipe_rst |=> (head_count == $past(head_count) ||
                   head_count == $past(head_count) + 1'b1 ||
                   head_count + 1'b1 == $past(head_count)));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_in && !rel_in && !pipe_rst && head_count == FULL) |=> (head_count == FULL));

  assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_dropped && !pipe_rst) |=> trig_dropped);

  assert_empty_release_R7: assert property (@(posedge clk) disable iff (rst)
    (rel_in && !trig_in && !pipe_rst && head_count == '0) |=> (head_count == '0));
endmodule

bind slice_trig_mgr slice_trig_mgr_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .pipe_rst(pipe_rst), .pipe_adv(pipe_adv),
  .trig_in(trig_in), .rel_in(rel_in), .wr_addr(wr_addr),
  .head_count(head_count), .trig_dropped(trig_dropped)
);

// File: tb/slice_trig_mgr_tb.sv
module slice_trig_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic       clk = 1'b0;
  logic       rst, pipe_rst, pipe_adv, trig_in, rel_in;
  logic [5:0] latency;
  logic [5:0] wr_addr, head_addr;
  logic [2:0] head_count;
  logic       trig_dropped;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_trig_mgr u_dut (
    .clk(clk), .rst(rst), .pipe_rst(pipe_rst), .pipe_adv(pipe_adv),
    .latency(latency), .trig_in(trig_in), .rel_in(rel_in),
    .wr_addr(wr_addr), .head_addr(head_addr), .head_count(head_count),
    .trig_dropped(trig_dropped)
  );

  // {adv, trig, rel, wr_addr, head_count, head_addr, dropped}, latency 3
  localparam logic [18:0] VEC [NV] = '{
    {3'b100, 6'd1, 3'd0, 6'd0, 1'b0},
    {3'b100, 6'd2, 3'd0, 6'd0, 1'b0},
    {3'b010, 6'd2, 3'd0, 6'd0, 1'b0},
    {3'b100, 6'd3, 3'd0, 6'd0, 1'b0},
    {3'b010, 6'd3, 3'd1, 6'd0, 1'b0},
    {3'b110, 6'd4, 3'd1, 6'd0, 1'b0},
    {3'b010, 6'd4, 3'd2, 6'd0, 1'b0},
    {3'b100, 6'd5, 3'd2, 6'd0, 1'b0},
    {3'b010, 6'd5, 3'd3, 6'd0, 1'b0},
    {3'b100, 6'd6, 3'd3, 6'd0, 1'b0},
    {3'b010, 6'd6, 3'd4, 6'd0, 1'b0},
    {3'b100, 6'd7, 3'd4, 6'd0, 1'b0},
    {3'b010, 6'd7, 3'd4, 6'd0, 1'b1},
    {3'b001, 6'd7, 3'd3, 6'd1, 1'b1},
    {3'b011, 6'd7, 3'd3, 6'd2, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic a, input logic t, input logic r);
    pipe_adv = a; trig_in = t; rel_in = r;
    @(negedge clk);
    pipe_adv = 1'b0; trig_in = 1'b0; rel_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1; pipe_rst = 1'b0; pipe_adv = 1'b0; trig_in = 1'b0; rel_in = 1'b0;
    latency = 6'd3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset wr_addr", wr_addr, 0);
    chk("R1 reset count", head_count, 0);
    chk("R1 reset head", head_addr, 0);
    chk("R1 reset flag", trig_dropped, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18], VEC[i][17], VEC[i][16]);
      chk($sformatf("R2/R4/R5 row %0d wr_addr", i), wr_addr, VEC[i][15:10]);
      chk($sformatf("R5/R8 row %0d count", i), head_count, VEC[i][9:7]);
      chk($sformatf("R5/R7 row %0d head", i), head_addr, VEC[i][6:1]);
      chk($sformatf("R6 row %0d flag", i), trig_dropped, VEC[i][0]);
    end

    // R2: walk to the top of the ring and wrap
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0);
    chk("R2 top slot", wr_addr, 47);
    step(1'b1, 1'b0, 1'b0);
    chk("R2 wrap to zero", wr_addr, 0);
    step(1'b1, 1'b0, 1'b0);
    chk("R2 after wrap", wr_addr, 1);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 skip protected 2..4", wr_addr, 5);

    // R4: look-back counts written slots (47,0,1), not address distance
    latency = 6'd2;
    step(1'b0, 1'b1, 1'b0);
    chk("R4 count after skip trigger", head_count, 4);
    chk("R4 head unchanged", head_addr, 2);

    step(1'b0, 1'b0, 1'b1);
    chk("R7 next oldest", head_addr, 3);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk("R7 last queued slot", head_addr, 0);
    step(1'b0, 1'b0, 1'b1);
    chk("R7 drained", head_count, 0);
    step(1'b0, 1'b0, 1'b1);
    chk("R7 empty release count", head_count, 0);
    chk("R7 empty release head", head_addr, 0);
    chk("R7 empty release wr_addr", wr_addr, 5);
    chk("R6 sticky flag", trig_dropped, 1);

    // R1: pipeline clear
    pipe_rst = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    pipe_rst = 1'b0;
    chk("R1 pipe_rst wr_addr", wr_addr, 0);
    chk("R1 pipe_rst count", head_count, 0);
    chk("R1 pipe_rst flag", trig_dropped, 0);

    // R8 and R4 with fresh history: slots 0,1,2 written
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    chk("R2 after clear", wr_addr, 3);
    latency = 6'd0;
    step(1'b0, 1'b1, 1'b0);
    chk("R8 latency zero ignored", head_count, 0);
    latency = 6'd48;
    step(1'b0, 1'b1, 1'b0);
    chk("R8 latency 48 ignored", head_count, 0);
    latency = 6'd1;
    step(1'b0, 1'b1, 1'b0);
    chk("R4 latency one count", head_count, 1);
    chk("R4 latency one slot", head_addr, 2);
    latency = 6'd3;
    step(1'b0, 1'b1, 1'b0);
    chk("R4 latency three count", head_count, 2);
    step(1'b0, 1'b1, 1'b0);
    chk("R8 already protected", head_count, 2);
    step(1'b0, 1'b0, 1'b1);
    chk("R7 pop order", head_addr, 0);
    chk("R7 pop count", head_count, 1);
    chk("R6 no flag on ignored", trig_dropped, 0);

    finish_run();
  end
endmodule